// File: doc/BRIEF.md
# Ethernet Transmit Status Tracker

This block follows one packet at a time through a half-duplex Ethernet transmitter and keeps a 24-bit status word for it. A packet-start strobe clears the word and latches the destination class of the new frame. From then on the block counts collision strobes, times how long the transmitter is held off by deferral, and notes a pause request. Every status event is masked by its own enable bit. An enabled event sets a sticky interrupt flag, and that flag drives the interrupt pin.

The collision count and the excessive-collision flag live in one 5-bit field. The sixteenth collision therefore carries into bit 4 and leaves bits 3:0 at zero. On that collision the block sends a one-cycle abort pulse, which tells the transmitter to drop the frame. The deferral limit is a fixed number of bit times. The number of clock cycles per bit depends on the speed select, so one parameter set covers both 10 and 100 Mbps.

Top module: `eth_tx_status_track`

## Requirements
- R1: `sw_reset` clears the whole status word, `irq_o` and `abort_o` on the next edge, and it wins over every other input in the same cycle.
- R2: `pkt_start` clears status bits 16:0. It loads bit 17 from `dst_mcast` and bit 18 from `dst_bcast`. Bits 23:19 and 16:8 always read 0.
- R3: Bits 3:0 count the collision strobes accepted for the current packet. A strobe in the same cycle as `pkt_start` counts as the new packet's first collision.
- R4: The sixteenth accepted collision makes bits 4:0 read 5'b10000. In the same cycle `abort_o` goes high, and it stays high for exactly one cycle.
- R5: Collision strobes have no effect once bit 4 is set. They also have no effect when no packet is in progress, meaning after `pkt_end` and before the next `pkt_start`.
- R6: Bit 5 is set when `defer_active` stays high during a packet for `DEFER_BITS * cycles-per-bit` consecutive edges. Cycles-per-bit is `CYC_100` when `speed_100` = 1 and `CYC_10` when `speed_100` = 0.
- R7: A deferral one edge shorter than the limit does not set bit 5. A drop of `defer_active` restarts the deferral timer.
- R8: Bit 6 is set when `pause_req` is high during a packet in progress, excluding the `pkt_start` cycle itself.
- R9: Bit 7 and `irq_o` are set when an event occurs whose enable bit is 1. The enable bits are: `int_en[0]` packet end, `int_en[1]` any accepted collision, `int_en[2]` excessive collisions, `int_en[3]` deferral timeout, `int_en[4]` pause. An event whose enable bit is 0 leaves the interrupt unchanged.
- R10: After a packet ends, the status word holds its value until the next `pkt_start` or `sw_reset`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sw_reset | input | 1 | Synchronous software reset of the status |
| pkt_start | input | 1 | First cycle of a new packet |
| pkt_end | input | 1 | Packet transmission finished |
| coll_strobe | input | 1 | One collision seen on the medium |
| defer_active | input | 1 | Transmitter is currently deferring |
| pause_req | input | 1 | Transmission will pause after this packet |
| speed_100 | input | 1 | 1 = 100 Mbps, 0 = 10 Mbps |
| dst_mcast | input | 1 | Destination is multicast (sampled at start) |
| dst_bcast | input | 1 | Destination is broadcast (sampled at start) |
| int_en | input | 5 | Per-event interrupt enables |
| status_o | output | 24 | Status word |
| irq_o | output | 1 | Interrupt request |
| abort_o | output | 1 | One-cycle drop-this-packet pulse |

## Verification
The cases hardest to reach from the ports are the deferral timeout and the sixteenth collision. At default parameters the timeout needs hundreds of thousands of cycles. The bench shrinks `DEFER_BITS` and the cycles-per-bit values so it can sweep deferral lengths one below, at and above the limit at both speeds. It also sweeps collision counts from 0 to 20, which drives the carry into bit 4 and then sends further strobes that must be ignored.

// File: rtl/eth_txs_pkg.sv
package eth_txs_pkg;
  localparam int unsigned STAT_W = 24;
  localparam int unsigned FLD_W  = 5;
  localparam int unsigned EV_W   = 5;
  // event index, shared with int_en bit positions
  localparam int unsigned EV_END   = 0;
  localparam int unsigned EV_COLL  = 1;
  localparam int unsigned EV_EXC   = 2;
  localparam int unsigned EV_DEFER = 3;
  localparam int unsigned EV_PAUSE = 4;

  // count and overflow flag share the field: the 16th bump carries into bit 4
  function automatic logic [FLD_W-1:0] coll_bump(input logic [FLD_W-1:0] f);
    return f + 1'b1;
  endfunction

  function automatic int unsigned defer_limit(input int unsigned bits,
                                              input int unsigned cyc_per_bit);
    return bits * cyc_per_bit;
  endfunction
endpackage

// File: rtl/tx_coll_field.sv
module tx_coll_field
  import eth_txs_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             sw_clr,
  input  logic             pkt_clr,
  input  logic             coll_in,
  output logic [FLD_W-1:0] field_o,
  output logic             coll_evt_o,
  output logic             exc_evt_o
);
  logic [FLD_W-1:0] fld_q;

  assign coll_evt_o = coll_in && !sw_clr && (pkt_clr || !fld_q[FLD_W-1]);
  assign exc_evt_o  = coll_evt_o && !pkt_clr && (coll_bump(fld_q) == 5'b10000);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          fld_q <= '0;
    else if (sw_clr)     fld_q <= '0;
    else if (pkt_clr)    fld_q <= coll_in ? 5'd1 : 5'd0;
    else if (coll_evt_o) fld_q <= coll_bump(fld_q);
  end

  assign field_o = fld_q;

  AST_EXC_LOW_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    fld_q[4] |-> (fld_q[3:0] == 4'd0)); // R4
  AST_EXC_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
    (fld_q[4] && !sw_clr && !pkt_clr) |=> $stable(fld_q)); // R5
endmodule

// File: rtl/tx_defer_timer.sv
module tx_defer_timer
  import eth_txs_pkg::*;
#(
  parameter int unsigned DEFER_BITS = 24288,
  parameter int unsigned CYC_10     = 10,
  parameter int unsigned CYC_100    = 1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clr,
  input  logic active,
  input  logic speed_100,
  output logic expire_o
);
  localparam int unsigned LIM10  = defer_limit(DEFER_BITS, CYC_10);
  localparam int unsigned LIM100 = defer_limit(DEFER_BITS, CYC_100);
  localparam int unsigned LIMMAX = (LIM10 > LIM100) ? LIM10 : LIM100;
  localparam int unsigned CW     = $clog2(LIMMAX + 1);
  localparam logic [CW-1:0] L10_V  = CW'(LIM10);
  localparam logic [CW-1:0] L100_V = CW'(LIM100);

  logic [CW-1:0] cnt_q;
  logic [CW-1:0] lim;

  assign lim      = speed_100 ? L100_V : L10_V;
  assign expire_o = active && !clr && (cnt_q == lim - 1'b1);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)               cnt_q <= '0;
    else if (clr || !active)  cnt_q <= '0;
    else if (cnt_q < lim)     cnt_q <= cnt_q + 1'b1;
  end

  AST_DEFER_SAT: assert property (@(posedge clk) disable iff (!rst_n)
    !active |=> (cnt_q == '0)); // R7
  AST_DEFER_ONCE: assert property (@(posedge clk) disable iff (!rst_n)
    expire_o |=> !expire_o); // R6
endmodule

// File: rtl/eth_tx_status_track.sv
module eth_tx_status_track
  import eth_txs_pkg::*;
#(
  parameter int unsigned DEFER_BITS = 24288,
  parameter int unsigned CYC_10     = 10,
  parameter int unsigned CYC_100    = 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sw_reset,
  input  logic              pkt_start,
  input  logic              pkt_end,
  input  logic              coll_strobe,
  input  logic              defer_active,
  input  logic              pause_req,
  input  logic              speed_100,
  input  logic              dst_mcast,
  input  logic              dst_bcast,
  input  logic [EV_W-1:0]   int_en,
  output logic [STAT_W-1:0] status_o,
  output logic              irq_o,
  output logic              abort_o
);
  logic in_pkt_q, defer_q, pause_q, int_q, mc_q, bc_q, abort_q;
  logic [FLD_W-1:0] fld;
  logic start_ok, coll_ok, coll_evt, exc_evt, defer_evt, pause_evt, end_evt;
  logic [EV_W-1:0] ev;
  logic int_hit;

  assign start_ok  = pkt_start && !sw_reset;
  assign coll_ok   = coll_strobe && (pkt_start || in_pkt_q);
  assign pause_evt = pause_req && in_pkt_q && !pkt_start && !sw_reset;
  assign end_evt   = pkt_end && in_pkt_q && !pkt_start && !sw_reset;

  tx_coll_field u_coll (
    .clk(clk), .rst_n(rst_n), .sw_clr(sw_reset), .pkt_clr(start_ok),
    .coll_in(coll_ok), .field_o(fld), .coll_evt_o(coll_evt), .exc_evt_o(exc_evt)
  );

  tx_defer_timer #(.DEFER_BITS(DEFER_BITS), .CYC_10(CYC_10), .CYC_100(CYC_100)) u_defer (
    .clk(clk), .rst_n(rst_n), .clr(sw_reset || pkt_start),
    .active(defer_active && in_pkt_q), .speed_100(speed_100), .expire_o(defer_evt)
  );

  always_comb begin
    ev = '0;
    ev[EV_END]   = end_evt;
    ev[EV_COLL]  = coll_evt;
    ev[EV_EXC]   = exc_evt;
    ev[EV_DEFER] = defer_evt;
    ev[EV_PAUSE] = pause_evt;
  end
  assign int_hit = |(ev & int_en);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      in_pkt_q <= 1'b0; defer_q <= 1'b0; pause_q <= 1'b0; int_q <= 1'b0;
      mc_q <= 1'b0; bc_q <= 1'b0; abort_q <= 1'b0;
    end else if (sw_reset) begin
      in_pkt_q <= 1'b0; defer_q <= 1'b0; pause_q <= 1'b0; int_q <= 1'b0;
      mc_q <= 1'b0; bc_q <= 1'b0; abort_q <= 1'b0;
    end else begin
      abort_q <= exc_evt;
      if (pkt_start) begin
        in_pkt_q <= 1'b1; defer_q <= 1'b0; pause_q <= 1'b0;
        int_q <= int_hit; mc_q <= dst_mcast; bc_q <= dst_bcast;
      end else begin
        if (pkt_end)   in_pkt_q <= 1'b0;
        if (defer_evt) defer_q  <= 1'b1;
        if (pause_evt) pause_q  <= 1'b1;
        if (int_hit)   int_q    <= 1'b1;
      end
    end
  end

  assign status_o = {5'b0, bc_q, mc_q, 9'b0, int_q, pause_q, defer_q, fld};
  assign irq_o    = int_q;
  assign abort_o  = abort_q;

  AST_SWRST_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    sw_reset |=> (status_o == '0 && !abort_o)); // R1
  AST_START_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    (start_ok && !coll_strobe) |=> (status_o[16:0] == '0)); // R2
  AST_ABORT_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    abort_o |=> !abort_o); // R4
  AST_ABORT_AT_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(status_o[4]) |-> abort_o); // R4
  AST_IRQ_ENABLED: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq_o) |-> $past(|int_en)); // R9
  AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    (!in_pkt_q && !pkt_start && !sw_reset) |=> $stable(status_o)); // R10
endmodule

// File: tb/tb_eth_tx_status_track.sv
module tb_eth_tx_status_track;
  localparam int unsigned DB = 4, C10 = 3, C100 = 1;
  localparam int unsigned L10 = DB * C10, L100 = DB * C100;

  logic clk = 0, rst_n = 0;
  logic sw_reset = 0, pkt_start = 0, pkt_end = 0, coll_strobe = 0;
  logic defer_active = 0, pause_req = 0, speed_100 = 1, dst_mcast = 0, dst_bcast = 0;
  logic [4:0] int_en = 0;
  logic [23:0] status_o;
  logic irq_o, abort_o;
  int checks = 0, fails = 0, aborts = 0;
  bit done = 0;

  always #4 clk = ~clk;

  eth_tx_status_track #(.DEFER_BITS(DB), .CYC_10(C10), .CYC_100(C100)) dut (
    .clk(clk), .rst_n(rst_n), .sw_reset(sw_reset), .pkt_start(pkt_start),
    .pkt_end(pkt_end), .coll_strobe(coll_strobe), .defer_active(defer_active),
    .pause_req(pause_req), .speed_100(speed_100), .dst_mcast(dst_mcast),
    .dst_bcast(dst_bcast), .int_en(int_en), .status_o(status_o),
    .irq_o(irq_o), .abort_o(abort_o));

  always @(negedge clk) if (abort_o) aborts++;

  task automatic step(); @(negedge clk); endtask

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic start_pkt(logic mc, logic bc, logic c);
    dst_mcast = mc; dst_bcast = bc; pkt_start = 1; coll_strobe = c;
    step(); pkt_start = 0; coll_strobe = 0;
  endtask

  task automatic end_pkt(); pkt_end = 1; step(); pkt_end = 0; step(); endtask

  task automatic colls(int n);
    for (int i = 0; i < n; i++) begin coll_strobe = 1; step(); coll_strobe = 0; step(); end
  endtask

  function automatic logic [4:0] exp_field(int n);
    return (n >= 16) ? 5'b10000 : 5'(n);
  endfunction

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      fails++; checks++;
      $display("FAIL watchdog expired");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    step(); step(); rst_n = 1; step();
    chk("R1 reset status", status_o, 0);
    chk("R1 reset irq/abort", {irq_o, abort_o}, 0);

    // R3 R4 R5: collision sweep 0..20
    for (int n = 0; n <= 20; n++) begin
      start_pkt(0, 0, 0);
      aborts = 0;
      colls(n);
      chk($sformatf("R3/R4 field n=%0d", n), status_o[4:0], exp_field(n));
      chk($sformatf("R4 abort count n=%0d", n), aborts, (n >= 16) ? 1 : 0);
      end_pkt();
    end
    // R3 collision in start cycle
    start_pkt(0, 0, 1);
    chk("R3 start-cycle collision", status_o[4:0], 1);
    colls(2);
    chk("R3 start plus two", status_o[4:0], 3);
    end_pkt();
    // R5 R10: strobes between packets ignored, status held
    colls(3); pause_req = 1; defer_active = 1;
    repeat (L10 + 2) step();
    pause_req = 0; defer_active = 0; step();
    chk("R5/R10 idle hold", status_o, 24'h3);

    // R2: type bits and clearing
    for (int t = 0; t < 4; t++) begin
      start_pkt(t[0], t[1], 0);
      chk($sformatf("R2 type t=%0d", t), status_o, {5'b0, t[1], t[0], 17'b0});
      end_pkt();
    end

    // R6 R7: deferral length sweep at both speeds
    for (int s = 0; s < 2; s++) begin
      int lim;
      speed_100 = s[0];
      lim = s[0] ? L100 : L10;
      for (int d = lim - 2; d <= lim + 1; d++) begin
        start_pkt(0, 0, 0);
        defer_active = 1; repeat (d) step(); defer_active = 0; step();
        chk($sformatf("R6/R7 defer spd=%0d d=%0d", s, d), status_o[5], d >= lim);
        end_pkt();
      end
      start_pkt(0, 0, 0);
      defer_active = 1; repeat (lim - 1) step(); defer_active = 0; step();
      defer_active = 1; repeat (lim - 1) step(); defer_active = 0; step();
      chk($sformatf("R7 restart spd=%0d", s), status_o[5], 0);
      end_pkt();
    end
    speed_100 = 1;

    // R8: pause during packet; pause only in start cycle ignored
    start_pkt(0, 0, 0);
    pause_req = 1; step(); pause_req = 0; step();
    chk("R8 pause set", status_o[6], 1);
    end_pkt();
    pause_req = 1; start_pkt(0, 0, 0); pause_req = 0; step();
    chk("R8 start-cycle pause ignored", status_o[6], 0);
    end_pkt();

    // R9: each event against each single enable
    for (int e = 0; e < 5; e++) begin
      for (int b = 0; b < 5; b++) begin
        logic expv;
        int_en = 5'(1 << b);
        start_pkt(0, 0, 0);
        case (e)
          0: begin pkt_end = 1; step(); pkt_end = 0; step(); end
          1: colls(1);
          2: colls(16);
          3: begin defer_active = 1; repeat (L100) step(); defer_active = 0; step(); end
          default: begin pause_req = 1; step(); pause_req = 0; step(); end
        endcase
        expv = (e == b) || (e == 2 && b == 1);
        chk($sformatf("R9 irq ev=%0d en=%0d", e, b), {irq_o, status_o[7]}, {expv, expv});
        if (e != 0) end_pkt();
      end
    end
    int_en = 0;

    // R1: software reset wins over start
    start_pkt(1, 1, 0); colls(4);
    sw_reset = 1; pkt_start = 1; coll_strobe = 1; step();
    sw_reset = 0; pkt_start = 0; coll_strobe = 0;
    chk("R1 sw reset priority", {status_o, irq_o, abort_o}, 0);

    done = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule